// File: doc/BRIEF.md
# Timer-Driven Descriptor Accumulator

This block keeps processors from polling hardware queues. A free-running tick timer starts a scan of the configured channels. During the scan the engine pops every descriptor it finds in each channel's queues and writes the popped descriptor addresses, one per word, into that channel's list area in accumulation memory. A channel raises its interrupt line when its list holds its programmed number of entries. It also raises the line on a later tick if the list holds at least one entry. Software drains the list, recycles the descriptors and acknowledges the channel.

One parameter picks one of two scan variants. In the high-priority variant every channel owns exactly one queue, and all channels are visited on every tick. In the low-priority variant every channel owns a bank of consecutive queues, and only one channel is visited per tick, in rotation. The engine asks the queue manager for a pop with `pop_req` and `pop_queue`. The queue manager returns the descriptor on `pop_desc` in the same cycle. Each list write leaves the block one cycle after its pop.

Top module: `acc_engine`

## Requirements
- R1: After reset `ch_irq`, `list_we` and `pop_req` are all low.
- R2: A scan starts only on a timer tick, and the tick fires once every `TICK_CYCLES` clocks. No pop happens before the first tick after reset.
- R3: In the high-priority variant every channel is visited on every tick. Channel c reads only queue c.
- R4: In the low-priority variant each tick visits one channel, in the order 0, 1, …, NUM_CH-1, 0, …. Channel c reads queues c*QPC to c*QPC+QPC-1 in ascending order, and the queues of the other channels are left untouched during that scan.
- R5: A queue is popped repeatedly while it is non-empty and the channel's count is below its threshold. Each popped descriptor is written to list address {channel, count}: the channel number sits above the low THR_W bits, and the count sits in those bits. The count then increments.
- R6: When a pop brings the count equal to the channel's threshold, the channel's `ch_irq` bit rises in the same cycle as that entry's list write.
- R7: On a tick, every enabled channel with a non-zero count and a low interrupt raises `ch_irq`.
- R8: While a channel's `ch_irq` is high, none of its queues is popped.
- R9: A one-cycle pulse on `ch_ack[c]` clears bit c of `ch_irq` and the count in the next cycle. The next entry of that channel goes to list word 0.
- R10: A channel with `ch_enable[c]` low is never popped and never raises its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_thresh | input | NUM_CH*THR_W | Per-channel list threshold; channel c uses bits c*THR_W +: THR_W |
| ch_ack | input | NUM_CH | Per-channel acknowledge pulse |
| q_nonempty | input | NUM_Q | Per-queue non-empty status from the queue manager |
| pop_req | output | 1 | Pop request; the descriptor is taken in this cycle |
| pop_queue | output | QW | Queue index being popped |
| pop_desc | input | DESC_W | Descriptor returned for the current pop |
| list_we | output | 1 | List memory write strobe |
| list_addr | output | CH_W+THR_W | List word address {channel, entry} |
| list_data | output | DESC_W | Descriptor address written |
| ch_irq | output | NUM_CH | Per-channel interrupt, held until acknowledged |

## Verification
The bench runs a small configuration of each variant against a queue model, and computes the expected list words from the queue indices and pop serial numbers. It targets four corner cases:
- A count that lands exactly on the threshold. An off-by-one design pops one descriptor too many or never interrupts.
- A channel held frozen after its interrupt. A faulty design keeps draining that channel's queue.
- The flush of a partial list on the following tick. A faulty design leaves entries stranded.
- An acknowledge. A faulty design fails to restart the list at word 0.

It also checks that the low-priority rotation leaves the other banks untouched, and that a disabled channel keeps its queue and stays silent.

// File: rtl/acc_pkg.sv
package acc_pkg;
    typedef enum logic {
        MODE_LOW  = 1'b0,
        MODE_HIGH = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/acc_tick_gen.sv
module acc_tick_gen #(
    parameter int unsigned PERIOD = 25000,
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == CW'(PERIOD - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/acc_scan_seq.sv
module acc_scan_seq
    import acc_pkg::*;
#(
    parameter acc_mode_e   MODE   = MODE_HIGH,
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned QPC    = 32,
    localparam int unsigned NUM_Q = (MODE == MODE_HIGH) ? NUM_CH : NUM_CH * QPC,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned LQ_W  = (QPC > 1) ? $clog2(QPC) : 1,
    localparam int unsigned QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            hold,
    output logic            busy,
    output logic [CH_W-1:0] cur_ch,
    output logic [QW-1:0]   cur_queue
);
    typedef struct packed {
        logic            busy;
        logic [CH_W-1:0] ch;
        logic [LQ_W-1:0] lq;
        logic [CH_W-1:0] rr;
    } seq_st_t;

    seq_st_t st_d, st_q;

    generate
        if (MODE == MODE_HIGH) begin : g_high
            always_comb begin
                st_d = st_q;
                if (!st_q.busy) begin
                    if (start) begin
                        st_d.busy = 1'b1;
                        st_d.ch   = '0;
                    end
                end else if (!hold) begin
                    if (st_q.ch == CH_W'(NUM_CH - 1)) st_d.busy = 1'b0;
                    else                               st_d.ch   = st_q.ch + 1'b1;
                end
            end
            assign cur_ch    = st_q.ch;
            assign cur_queue = QW'(st_q.ch);
        end else begin : g_low
            always_comb begin
                st_d = st_q;
                if (!st_q.busy) begin
                    if (start) begin
                        st_d.busy = 1'b1;
                        st_d.lq   = '0;
                    end
                end else if (!hold) begin
                    if (st_q.lq == LQ_W'(QPC - 1)) begin
                        st_d.busy = 1'b0;
                        st_d.rr   = (st_q.rr == CH_W'(NUM_CH - 1)) ? '0 : st_q.rr + 1'b1;
                    end else begin
                        st_d.lq = st_q.lq + 1'b1;
                    end
                end
            end
            assign cur_ch    = st_q.rr;
            assign cur_queue = QW'(st_q.rr) * QW'(QPC) + QW'(st_q.lq);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/acc_engine.sv
module acc_engine
    import acc_pkg::*;
#(
    parameter acc_mode_e   MODE        = MODE_HIGH,
    parameter int unsigned NUM_CH      = 32,
    parameter int unsigned QPC         = 32,
    parameter int unsigned TICK_CYCLES = 25000,
    parameter int unsigned DESC_W      = 32,
    parameter int unsigned THR_W       = 6,
    localparam int unsigned NUM_Q = (MODE == MODE_HIGH) ? NUM_CH : NUM_CH * QPC,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int unsigned LA_W  = CH_W + THR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_enable,
    input  logic [NUM_CH*THR_W-1:0] ch_thresh,
    input  logic [NUM_CH-1:0]       ch_ack,
    input  logic [NUM_Q-1:0]        q_nonempty,
    output logic                    pop_req,
    output logic [QW-1:0]           pop_queue,
    input  logic [DESC_W-1:0]       pop_desc,
    output logic                    list_we,
    output logic [LA_W-1:0]         list_addr,
    output logic [DESC_W-1:0]       list_data,
    output logic [NUM_CH-1:0]       ch_irq
);
    typedef struct packed {
        logic [NUM_CH-1:0][THR_W-1:0] cnt;
        logic [NUM_CH-1:0]            irq;
        logic                         we;
        logic [LA_W-1:0]              addr;
        logic [DESC_W-1:0]            data;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic            tick;
    logic            busy;
    logic [CH_W-1:0] cur_ch;
    logic [QW-1:0]   cur_queue;
    logic [THR_W-1:0] cur_thr;
    logic [THR_W-1:0] cur_cnt;
    logic            take;

    acc_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    acc_scan_seq #(.MODE(MODE), .NUM_CH(NUM_CH), .QPC(QPC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tick),
        .hold      (take),
        .busy      (busy),
        .cur_ch    (cur_ch),
        .cur_queue (cur_queue)
    );

    always_comb begin
        cur_thr = ch_thresh[int'(cur_ch) * THR_W +: THR_W];
        cur_cnt = st_q.cnt[cur_ch];
        take    = busy && ch_enable[cur_ch] && !st_q.irq[cur_ch] && !ch_ack[cur_ch]
                  && q_nonempty[cur_queue] && (cur_cnt < cur_thr);

        st_d    = st_q;
        st_d.we = take;

        // tick flush of partially filled lists
        for (int i = 0; i < NUM_CH; i++) begin
            if (tick && ch_enable[i] && !st_q.irq[i] && (st_q.cnt[i] != '0))
                st_d.irq[i] = 1'b1;
        end

        if (take) begin
            st_d.addr         = {cur_ch, cur_cnt};
            st_d.data         = pop_desc;
            st_d.cnt[cur_ch]  = cur_cnt + 1'b1;
            if (THR_W'(cur_cnt + 1'b1) == cur_thr)
                st_d.irq[cur_ch] = 1'b1;
        end

        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_ack[i]) begin
                st_d.cnt[i] = '0;
                st_d.irq[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_req   = take;
    assign pop_queue = cur_queue;
    assign list_we   = st_q.we;
    assign list_addr = st_q.addr;
    assign list_data = st_q.data;
    assign ch_irq    = st_q.irq;
endmodule

// File: rtl/acc_engine_chk.sv
module acc_engine_chk
    import acc_pkg::*;
#(
    parameter acc_mode_e   MODE   = MODE_HIGH,
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned QPC    = 32,
    parameter int unsigned DESC_W = 32,
    parameter int unsigned THR_W  = 6,
    localparam int unsigned NUM_Q = (MODE == MODE_HIGH) ? NUM_CH : NUM_CH * QPC,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int unsigned LA_W  = CH_W + THR_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       ch_enable,
    input logic [NUM_CH*THR_W-1:0] ch_thresh,
    input logic [NUM_CH-1:0]       ch_ack,
    input logic [NUM_Q-1:0]        q_nonempty,
    input logic                    pop_req,
    input logic [QW-1:0]           pop_queue,
    input logic [DESC_W-1:0]       pop_desc,
    input logic                    list_we,
    input logic [LA_W-1:0]         list_addr,
    input logic [DESC_W-1:0]       list_data,
    input logic [NUM_CH-1:0]       ch_irq
);
    logic [CH_W-1:0]  pop_ch;
    logic [CH_W-1:0]  wr_ch;
    logic [THR_W-1:0] wr_thr;

    assign pop_ch = (MODE == MODE_HIGH) ? CH_W'(pop_queue) : CH_W'(int'(pop_queue) / int'(QPC));
    assign wr_ch  = list_addr[LA_W-1:THR_W];
    assign wr_thr = ch_thresh[int'(wr_ch) * THR_W +: THR_W];

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> q_nonempty[pop_queue]); // R5
    AST_POP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> ch_enable[pop_ch]); // R10
    AST_NO_POP_WHILE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> !ch_irq[pop_ch]); // R8
    AST_WRITE_FOLLOWS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> (list_we && list_data == $past(pop_desc))); // R5
    AST_ENTRY_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        list_we |-> (list_addr[THR_W-1:0] < wr_thr)); // R6

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                ch_ack[i] |=> !ch_irq[i]); // R9
            AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_irq[i]) |-> $past(ch_enable[i])); // R10
        end
    endgenerate
endmodule

bind acc_engine acc_engine_chk #(
    .MODE(MODE), .NUM_CH(NUM_CH), .QPC(QPC), .DESC_W(DESC_W), .THR_W(THR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_thresh(ch_thresh),
    .ch_ack(ch_ack), .q_nonempty(q_nonempty), .pop_req(pop_req),
    .pop_queue(pop_queue), .pop_desc(pop_desc), .list_we(list_we),
    .list_addr(list_addr), .list_data(list_data), .ch_irq(ch_irq)
);

// File: tb/tb_acc_engine.sv
module tb_acc_engine;
    import acc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 64;
    localparam int NCH        = 4;
    localparam int QPC        = 4;
    localparam int THR_W      = 6;
    localparam int DW         = 32;
    localparam int HNQ        = NCH;
    localparam int LNQ        = NCH * QPC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // ---------------- high-priority instance ----------------
    logic [NCH-1:0]       h_en, h_ack, h_irq;
    logic [NCH*THR_W-1:0] h_thr;
    logic [HNQ-1:0]       h_ne;
    logic                 h_pop, h_we;
    logic [1:0]           h_pq;
    logic [DW-1:0]        h_pd, h_data;
    logic [7:0]           h_addr;
    int h_rem [HNQ];
    int h_srv [HNQ];
    int h_mem [256];
    int h_wc  [NCH];
    localparam int H_INIT [HNQ] = '{5, 2, 4, 1};

    acc_engine #(.MODE(MODE_HIGH), .NUM_CH(NCH), .QPC(QPC), .TICK_CYCLES(TICK),
                 .DESC_W(DW), .THR_W(THR_W)) dut (
        .clk(clk), .rst_n(rst_n), .ch_enable(h_en), .ch_thresh(h_thr),
        .ch_ack(h_ack), .q_nonempty(h_ne), .pop_req(h_pop), .pop_queue(h_pq),
        .pop_desc(h_pd), .list_we(h_we), .list_addr(h_addr), .list_data(h_data),
        .ch_irq(h_irq)
    );

    always_comb for (int i = 0; i < HNQ; i++) h_ne[i] = (h_rem[i] > 0);
    assign h_pd = DW'((int'(h_pq) << 8) | h_srv[h_pq]);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HNQ; i++) begin
                h_rem[i] <= H_INIT[i];
                h_srv[i] <= 0;
            end
        end else if (h_pop) begin
            h_rem[h_pq] <= h_rem[h_pq] - 1;
            h_srv[h_pq] <= h_srv[h_pq] + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && h_we) begin
            h_mem[h_addr] = int'(h_data);
            h_wc[h_addr[7:6]] = h_wc[h_addr[7:6]] + 1;
        end
    end

    // ---------------- low-priority instance ----------------
    logic [NCH-1:0]       l_en, l_ack, l_irq;
    logic [NCH*THR_W-1:0] l_thr;
    logic [LNQ-1:0]       l_ne;
    logic                 l_pop, l_we;
    logic [3:0]           l_pq;
    logic [DW-1:0]        l_pd, l_data;
    logic [7:0]           l_addr;
    int l_rem [LNQ];
    int l_srv [LNQ];
    int l_mem [256];
    localparam int L_INIT [LNQ] = '{2, 0, 3, 1, 1, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0};
    localparam int L_EXP  [6]   = '{'h000, 'h001, 'h200, 'h201, 'h202, 'h300};

    acc_engine #(.MODE(MODE_LOW), .NUM_CH(NCH), .QPC(QPC), .TICK_CYCLES(TICK),
                 .DESC_W(DW), .THR_W(THR_W)) dut_lo (
        .clk(clk), .rst_n(rst_n), .ch_enable(l_en), .ch_thresh(l_thr),
        .ch_ack(l_ack), .q_nonempty(l_ne), .pop_req(l_pop), .pop_queue(l_pq),
        .pop_desc(l_pd), .list_we(l_we), .list_addr(l_addr), .list_data(l_data),
        .ch_irq(l_irq)
    );

    always_comb for (int i = 0; i < LNQ; i++) l_ne[i] = (l_rem[i] > 0);
    assign l_pd = DW'((int'(l_pq) << 8) | l_srv[l_pq]);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LNQ; i++) begin
                l_rem[i] <= L_INIT[i];
                l_srv[i] <= 0;
            end
        end else if (l_pop) begin
            l_rem[l_pq] <= l_rem[l_pq] - 1;
            l_srv[l_pq] <= l_srv[l_pq] + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && l_we) l_mem[l_addr] = int'(l_data);
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int cyc, inout int now);
        while (now < cyc) begin
            @(negedge clk);
            now++;
        end
    endtask

    initial begin
        int now;
        now   = 0;
        h_en  = 4'b1011;
        l_en  = 4'b1011;
        h_ack = '0;
        l_ack = '0;
        h_thr = {6'd1, 6'd2, 6'd5, 6'd3};
        l_thr = {4{6'd6}};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        now = 1;
        chk("R1", "high irq/we/pop", {29'd0, h_irq[0] | h_irq[1] | h_irq[2] | h_irq[3], h_we, h_pop}, 0);
        chk("R1", "low irq/we/pop", {29'd0, |l_irq, l_we, l_pop}, 0);

        wait_to(TICK - 4, now);
        chk("R2", "high q0 untouched before tick", h_rem[0], 5);
        chk("R2", "low q0 untouched before tick", l_rem[0], 2);

        wait_to(TICK + 30, now);
        chk("R5", "high ch0 entry count", h_wc[0], 3);
        chk("R3", "high ch1 entry count", h_wc[1], 2);
        chk("R10", "high ch2 entry count", h_wc[2], 0);
        chk("R3", "high ch3 entry count", h_wc[3], 1);
        for (int k = 0; k < 3; k++) chk("R5", "high ch0 list word", h_mem[k], k);
        for (int k = 0; k < 2; k++) chk("R5", "high ch1 list word", h_mem[64 + k], 'h100 + k);
        chk("R3", "high ch3 list word0", h_mem[192], 'h300);
        chk("R6", "high irq after scan", int'(h_irq), 'b1001);
        chk("R10", "high q2 remaining", h_rem[2], 4);
        for (int k = 0; k < 6; k++) chk("R4", "low ch0 list word", l_mem[k], L_EXP[k]);
        chk("R6", "low irq after scan", int'(l_irq), 'b0001);
        chk("R4", "low q4 untouched on ch0 turn", l_rem[4], 1);

        wait_to(2 * TICK + 30, now);
        chk("R7", "high irq after flush tick", int'(h_irq), 'b1011);
        chk("R8", "high q0 frozen while irq", h_rem[0], 2);
        chk("R4", "low q4 drained on ch1 turn", l_rem[4], 0);
        chk("R4", "low ch1 list word0", l_mem[64], 'h400);
        chk("R7", "low irq before ch1 flush", int'(l_irq), 'b0001);

        h_ack = 4'b0001;
        l_ack = 4'b0001;
        @(negedge clk);
        now++;
        h_ack = '0;
        l_ack = '0;
        wait_to(2 * TICK + 33, now);
        chk("R9", "high irq after ack", int'(h_irq), 'b1010);
        chk("R9", "low irq after ack", int'(l_irq), 'b0000);

        wait_to(3 * TICK + 30, now);
        chk("R9", "high ch0 word0 after ack", h_mem[0], 3);
        chk("R9", "high ch0 word1 after ack", h_mem[1], 4);
        chk("R6", "high ch0 below threshold no irq", int'(h_irq[0]), 0);
        chk("R7", "low ch1 flushed", int'(l_irq), 'b0010);
        chk("R10", "low q8 of disabled ch2", l_rem[8], 2);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule